// File: doc/BRIEF.md
# Video-Mode Display Packet Header Sequencer

This block walks one video frame line by line and produces the ordered list of packet headers that a display serial link transmitter must send. Every line carries a start code, optional horizontal blanking spans, the pixel payload slot and an optional end-of-transmission packet. Each header is handed to a downstream packet builder over a valid/ready handshake. A header holds a one-byte identifier (virtual channel in bits [7:6], data type in bits [5:0]) and a 16-bit word count. Two flags mark long packets and packets whose payload is pixel data.

The frame timing is set by four line counts (sync, back porch, active, front porch) and by byte sizes for the horizontal sync area, back porch, active line, front porch and the non-burst null fill. Mode bits choose sync-pulse or sync-event timing, burst or non-burst fill, 24-bit or 16-bit pixel packets, extra sync-end packets on blanking lines, omission of single horizontal regions, omission of the end-of-transmission packet, and an automatic vertical count that drops the sync and back-porch lines. All settings are captured when a frame starts. While `run` is high, frames follow one another without a gap.

Top module: `dsi_vid_seq`

## Requirements
- R1: After reset, and while `run` stays low, `hdr_valid` and `frame_done` stay low.
- R2: Every header identifier is {virtual channel, data type}, with the channel in bits [7:6] taken from `cfg_vc` at frame start. Short packets carry word count 0.
- R3: Lines go in this order: sync lines, back-porch lines, active lines, front-porch lines. The first packet of the first sync line has data type 0x01. Every other line starts with 0x21.
- R4: In sync-pulse mode (`cfg_pulse`=1), active lines and the last sync line carry a sync-end packet after the start code. It is 0x11 on the last sync line and 0x31 elsewhere. It is preceded by a horizontal sync blanking packet (0x19, word count `cfg_hsa_wc`). In sync-event mode, active lines carry no sync-end packet.
- R5: With `cfg_hse`=1, every line that is not active also carries the sync-end packet (0x31, or 0x11 on the last sync line in pulse mode). With `cfg_hse`=0, such lines carry it only on the last sync line in pulse mode.
- R6: Per-line order after the sync part is: back-porch blanking (0x19), payload slot, null fill, front-porch blanking (0x19). `cfg_skip_hsa`, `cfg_skip_hbp` and `cfg_skip_hfp` each remove one blanking packet. Any long packet whose word count would be 0 is not emitted.
- R7: On active lines the payload slot is a long packet of type 0x3e (`cfg_fmt16`=0) or 0x0e (`cfg_fmt16`=1), with word count `cfg_hact_wc` and `hdr_pix`=1. On other lines it is blanking 0x19 with the same word count and `hdr_pix`=0.
- R8: In non-burst mode (`cfg_burst`=0), each active line carries a null packet (0x09, word count `cfg_null_wc`) right after the pixel packet. In burst mode no null packet is emitted.
- R9: Each line ends with an end-of-transmission packet (0x08) unless `cfg_eot_off`=1.
- R10: With `cfg_auto_v`=1 the frame has only its active and front-porch lines. No 0x01 packet is sent.
- R11: While `hdr_valid` is high and `hdr_ready` is low, the header and its flags hold steady and `hdr_valid` stays high.
- R12: Configuration inputs changed during a frame do not affect that frame.
- R13: `frame_done` pulses for exactly one cycle after the last header of a frame is accepted. If `run` is high at that point, the next frame starts right away with freshly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start a frame when idle or at frame end |
| cfg_vsync_lines | input | LINE_W | Vertical sync line count |
| cfg_vbp_lines | input | LINE_W | Vertical back-porch line count |
| cfg_vact_lines | input | LINE_W | Active line count |
| cfg_vfp_lines | input | LINE_W | Vertical front-porch line count |
| cfg_hsa_wc | input | WC_W | Horizontal sync area bytes |
| cfg_hbp_wc | input | WC_W | Horizontal back-porch bytes |
| cfg_hact_wc | input | WC_W | Active line bytes |
| cfg_hfp_wc | input | WC_W | Horizontal front-porch bytes |
| cfg_null_wc | input | WC_W | Null fill bytes in non-burst mode |
| cfg_vc | input | 2 | Virtual channel |
| cfg_fmt16 | input | 1 | 1: 16-bit pixel packets, 0: 24-bit |
| cfg_pulse | input | 1 | 1: sync-pulse timing, 0: sync-event |
| cfg_burst | input | 1 | 1: burst fill, 0: non-burst with null packets |
| cfg_hse | input | 1 | Sync-end packet on vertical blanking lines |
| cfg_skip_hsa | input | 1 | Omit horizontal sync blanking |
| cfg_skip_hbp | input | 1 | Omit horizontal back-porch blanking |
| cfg_skip_hfp | input | 1 | Omit horizontal front-porch blanking |
| cfg_eot_off | input | 1 | Omit end-of-transmission packets |
| cfg_auto_v | input | 1 | Drop sync and back-porch lines |
| hdr_valid | output | 1 | Header request valid |
| hdr_ready | input | 1 | Downstream accepts header |
| hdr_id | output | 8 | {virtual channel, data type} |
| hdr_wc | output | WC_W | Word count |
| hdr_long | output | 1 | Long packet, payload follows |
| hdr_pix | output | 1 | Payload is pixel data |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Seven timing and mode sets are run as whole frames, and the full header stream is compared entry by entry. They separate sync-event from sync-pulse frames (missing or extra 0x31/0x11, and where the horizontal sync blanking sits), burst from non-burst (null packets present or absent), and each skip flag (exactly one blanking packet gone). A set with zero-sized regions and no sync lines shows that empty packets are dropped and that 0x01 appears only when sync lines exist. Directed runs stall the handshake mid-frame, change the settings mid-frame, and keep `run` high across two frames to show the settings are captured once and the end pulse lasts one cycle.

// File: rtl/dsi_vid_seq.sv
module dsi_vid_seq #(
  parameter int LINE_W = 12,
  parameter int WC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LINE_W-1:0] cfg_vsync_lines,
  input  logic [LINE_W-1:0] cfg_vbp_lines,
  input  logic [LINE_W-1:0] cfg_vact_lines,
  input  logic [LINE_W-1:0] cfg_vfp_lines,
  input  logic [WC_W-1:0]   cfg_hsa_wc,
  input  logic [WC_W-1:0]   cfg_hbp_wc,
  input  logic [WC_W-1:0]   cfg_hact_wc,
  input  logic [WC_W-1:0]   cfg_hfp_wc,
  input  logic [WC_W-1:0]   cfg_null_wc,
  input  logic [1:0]        cfg_vc,
  input  logic              cfg_fmt16,
  input  logic              cfg_pulse,
  input  logic              cfg_burst,
  input  logic              cfg_hse,
  input  logic              cfg_skip_hsa,
  input  logic              cfg_skip_hbp,
  input  logic              cfg_skip_hfp,
  input  logic              cfg_eot_off,
  input  logic              cfg_auto_v,
  output logic              hdr_valid,
  input  logic              hdr_ready,
  output logic [7:0]        hdr_id,
  output logic [WC_W-1:0]   hdr_wc,
  output logic              hdr_long,
  output logic              hdr_pix,
  output logic              frame_done
);

  localparam int CW = LINE_W + 2;
  localparam int NSTEP = 8;

  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_VSE   = 6'h11;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_BLANK = 6'h19;
  localparam logic [5:0] DT_NULL  = 6'h09;
  localparam logic [5:0] DT_EOT   = 6'h08;
  localparam logic [5:0] DT_RGB24 = 6'h3e;
  localparam logic [5:0] DT_RGB16 = 6'h0e;

  localparam logic [2:0] S_START = 3'd0;
  localparam logic [2:0] S_HSA   = 3'd1;
  localparam logic [2:0] S_END   = 3'd2;
  localparam logic [2:0] S_HBP   = 3'd3;
  localparam logic [2:0] S_ACT   = 3'd4;
  localparam logic [2:0] S_NULL  = 3'd5;
  localparam logic [2:0] S_HFP   = 3'd6;
  localparam logic [2:0] S_EOT   = 3'd7;

  logic              busy;
  logic [CW-1:0]     ln;
  logic [3:0]        st;
  logic [LINE_W-1:0] c_vs, c_vb, c_va, c_vf;
  logic [WC_W-1:0]   c_hsa, c_hbp, c_hact, c_hfp, c_null;
  logic [1:0]        c_vc;
  logic              c_fmt16, c_pulse, c_burst, c_hse;
  logic              c_skip_hsa, c_skip_hbp, c_skip_hfp, c_eot_off;

  wire [CW-1:0] b_sync = CW'(c_vs);
  wire [CW-1:0] b_bp   = b_sync + CW'(c_vb);
  wire [CW-1:0] b_act  = b_bp + CW'(c_va);
  wire [CW-1:0] b_all  = b_act + CW'(c_vf);

  wire live       = ln < b_all;
  wire in_sync    = ln < b_sync;
  wire in_act     = (ln >= b_bp) && (ln < b_act);
  wire first_sync = in_sync && (ln == '0);
  wire last_sync  = in_sync && (ln + CW'(1) == b_sync);
  wire last_line  = (ln + CW'(1)) >= b_all;
  wire end_pkt    = (c_pulse && (in_act || last_sync)) || (c_hse && !in_act);

  logic [NSTEP-1:0] pres;
  assign pres = {
    !c_eot_off,
    !c_skip_hfp && (c_hfp != '0),
    in_act && !c_burst && (c_null != '0),
    c_hact != '0,
    !c_skip_hbp && (c_hbp != '0),
    end_pkt,
    end_pkt && c_pulse && !c_skip_hsa && (c_hsa != '0),
    1'b1
  };

  logic       found;
  logic [2:0] cur;
  always_comb begin
    found = 1'b0;
    cur   = S_START;
    for (int i = 0; i < NSTEP; i++) begin
      if (!found && (i >= int'(st)) && pres[i]) begin
        found = 1'b1;
        cur   = 3'(i);
      end
    end
  end

  wire line_end  = busy && (!found || !live);
  wire frame_end = line_end && last_line;
  wire load      = run && (!busy || frame_end);

  assign hdr_valid = busy && live && found;
  wire fire = hdr_valid && hdr_ready;

  logic [5:0]      dt;
  logic [WC_W-1:0] wc;
  logic            lng, pix;
  always_comb begin
    dt  = DT_EOT;
    wc  = '0;
    lng = 1'b0;
    pix = 1'b0;
    case (cur)
      S_START: dt = first_sync ? DT_VSS : DT_HSS;
      S_HSA:   begin dt = DT_BLANK; wc = c_hsa; lng = 1'b1; end
      S_END:   dt = (c_pulse && last_sync) ? DT_VSE : DT_HSE;
      S_HBP:   begin dt = DT_BLANK; wc = c_hbp; lng = 1'b1; end
      S_ACT: begin
        dt  = in_act ? (c_fmt16 ? DT_RGB16 : DT_RGB24) : DT_BLANK;
        wc  = c_hact;
        lng = 1'b1;
        pix = in_act;
      end
      S_NULL:  begin dt = DT_NULL; wc = c_null; lng = 1'b1; end
      S_HFP:   begin dt = DT_BLANK; wc = c_hfp; lng = 1'b1; end
      default: dt = DT_EOT;
    endcase
  end

  assign hdr_id   = hdr_valid ? {c_vc, dt} : 8'h00;
  assign hdr_wc   = hdr_valid ? wc : '0;
  assign hdr_long = hdr_valid && lng;
  assign hdr_pix  = hdr_valid && pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ln         <= '0;
      st         <= '0;
      frame_done <= 1'b0;
      c_vs       <= '0;
      c_vb       <= '0;
      c_va       <= '0;
      c_vf       <= '0;
      c_hsa      <= '0;
      c_hbp      <= '0;
      c_hact     <= '0;
      c_hfp      <= '0;
      c_null     <= '0;
      c_vc       <= '0;
      c_fmt16    <= 1'b0;
      c_pulse    <= 1'b0;
      c_burst    <= 1'b0;
      c_hse      <= 1'b0;
      c_skip_hsa <= 1'b0;
      c_skip_hbp <= 1'b0;
      c_skip_hfp <= 1'b0;
      c_eot_off  <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (load) begin
        busy       <= 1'b1;
        ln         <= '0;
        st         <= '0;
        c_vs       <= cfg_auto_v ? '0 : cfg_vsync_lines;
        c_vb       <= cfg_auto_v ? '0 : cfg_vbp_lines;
        c_va       <= cfg_vact_lines;
        c_vf       <= cfg_vfp_lines;
        c_hsa      <= cfg_hsa_wc;
        c_hbp      <= cfg_hbp_wc;
        c_hact     <= cfg_hact_wc;
        c_hfp      <= cfg_hfp_wc;
        c_null     <= cfg_null_wc;
        c_vc       <= cfg_vc;
        c_fmt16    <= cfg_fmt16;
        c_pulse    <= cfg_pulse;
        c_burst    <= cfg_burst;
        c_hse      <= cfg_hse;
        c_skip_hsa <= cfg_skip_hsa;
        c_skip_hbp <= cfg_skip_hbp;
        c_skip_hfp <= cfg_skip_hfp;
        c_eot_off  <= cfg_eot_off;
      end else if (frame_end) begin
        busy <= 1'b0;
      end else if (line_end) begin
        ln <= ln + CW'(1);
        st <= '0;
      end else if (fire) begin
        st <= {1'b0, cur} + 4'd1;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable({hdr_id, hdr_wc, hdr_long, hdr_pix}));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_vc_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && $past(hdr_valid) |-> $stable(hdr_id[7:6]));

  p_no_null_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && c_burst |-> hdr_id[5:0] != DT_NULL);

  p_pix_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pix |-> hdr_valid && hdr_long && (hdr_id[5:0] == DT_RGB24 || hdr_id[5:0] == DT_RGB16));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !hdr_valid);

endmodule

// File: tb/sim_dsi_vid_seq.sv
`timescale 1ns/1ps
module sim_dsi_vid_seq;

  typedef struct packed {
    logic [7:0]  vs, vb, va, vf;
    logic [15:0] hsa, hbp, hact, hfp, nul;
    logic [1:0]  vc;
    logic fmt16, pulse, burst, hse, shsa, shbp, shfp, eotoff, autov;
  } cfg_t;

  localparam int NROW = 7;
  localparam cfg_t ROWS [NROW] = '{
    '{8'd2, 8'd1, 8'd3, 8'd2, 16'd4, 16'd6, 16'd12, 16'd5, 16'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd2, 8'd1, 8'd3, 8'd1, 16'd4, 16'd6, 16'd12, 16'd5, 16'd8, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd1, 8'd2, 8'd2, 8'd1, 16'd4, 16'd6, 16'd10, 16'd5, 16'd8, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd2, 8'd1, 8'd2, 8'd1, 16'd4, 16'd6, 16'd10, 16'd5, 16'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd3, 8'd2, 8'd2, 8'd1, 16'd4, 16'd6, 16'd10, 16'd5, 16'd6, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'd2, 8'd2, 8'd2, 8'd2, 16'd4, 16'd6, 16'd10, 16'd0, 16'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd0, 8'd0, 8'd2, 8'd1, 16'd0, 16'd3, 16'd8, 16'd2, 16'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R3 R7";
      1: return "R4 R8 R2";
      2: return "R5";
      3: return "R6 R9";
      4: return "R10";
      5: return "R5 R6 R2";
      default: return "R8 R6 R3";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  cfg_t cfg = '0;
  logic hdr_valid, hdr_ready, hdr_long, hdr_pix, frame_done;
  logic [7:0]  hdr_id;
  logic [15:0] hdr_wc;

  always #2.5 clk = ~clk;

  dsi_vid_seq u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_vsync_lines(12'(cfg.vs)), .cfg_vbp_lines(12'(cfg.vb)),
    .cfg_vact_lines(12'(cfg.va)), .cfg_vfp_lines(12'(cfg.vf)),
    .cfg_hsa_wc(cfg.hsa), .cfg_hbp_wc(cfg.hbp), .cfg_hact_wc(cfg.hact),
    .cfg_hfp_wc(cfg.hfp), .cfg_null_wc(cfg.nul), .cfg_vc(cfg.vc),
    .cfg_fmt16(cfg.fmt16), .cfg_pulse(cfg.pulse), .cfg_burst(cfg.burst),
    .cfg_hse(cfg.hse), .cfg_skip_hsa(cfg.shsa), .cfg_skip_hbp(cfg.shbp),
    .cfg_skip_hfp(cfg.shfp), .cfg_eot_off(cfg.eotoff), .cfg_auto_v(cfg.autov),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_id(hdr_id), .hdr_wc(hdr_wc),
    .hdr_long(hdr_long), .hdr_pix(hdr_pix), .frame_done(frame_done)
  );

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int wide_done = 0;
  int cycles = 0;
  logic prev_done = 1'b0;
  logic bp_on = 1'b0;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic [25:0] got [$];
  logic [25:0] exp_q [$];

  assign hdr_ready = !stall && (!bp_on || lfsr[0] || lfsr[3]);

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(negedge clk) begin
    if (hdr_valid && hdr_ready) got.push_back({hdr_long, hdr_pix, hdr_id, hdr_wc});
    if (frame_done) done_cnt++;
    if (frame_done && prev_done) wide_done++;
    prev_done <= frame_done;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [25:0] pk(bit lng, bit px, logic [1:0] vc, logic [5:0] dt, logic [15:0] wc);
    return {lng, px, vc, dt, wc};
  endfunction

  task automatic build(cfg_t c);
    int n [4];
    n[0] = c.autov ? 0 : int'(c.vs);
    n[1] = c.autov ? 0 : int'(c.vb);
    n[2] = int'(c.va);
    n[3] = int'(c.vf);
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < n[r]; k++) begin
        bit act = (r == 2);
        bit lastvs = (r == 0) && (k == n[0] - 1);
        bit endp = (c.pulse && (act || lastvs)) || (c.hse && !act);
        exp_q.push_back(pk(0, 0, c.vc, (r == 0 && k == 0) ? 6'h01 : 6'h21, 16'd0));
        if (endp && c.pulse && !c.shsa && c.hsa != 0) exp_q.push_back(pk(1, 0, c.vc, 6'h19, c.hsa));
        if (endp) exp_q.push_back(pk(0, 0, c.vc, (c.pulse && lastvs) ? 6'h11 : 6'h31, 16'd0));
        if (!c.shbp && c.hbp != 0) exp_q.push_back(pk(1, 0, c.vc, 6'h19, c.hbp));
        if (c.hact != 0) begin
          if (act) exp_q.push_back(pk(1, 1, c.vc, c.fmt16 ? 6'h0e : 6'h3e, c.hact));
          else     exp_q.push_back(pk(1, 0, c.vc, 6'h19, c.hact));
        end
        if (act && !c.burst && c.nul != 0) exp_q.push_back(pk(1, 0, c.vc, 6'h09, c.nul));
        if (!c.shfp && c.hfp != 0) exp_q.push_back(pk(1, 0, c.vc, 6'h19, c.hfp));
        if (!c.eotoff) exp_q.push_back(pk(0, 0, c.vc, 6'h08, 16'd0));
      end
    end
  endtask

  task automatic compare(string req);
    chk(got.size() == exp_q.size(), req, "packet count", 64'(got.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++) begin
      logic [25:0] g = (i < got.size()) ? got[i] : '1;
      chk(g == exp_q[i], req, $sformatf("packet %0d", i), 64'(g), 64'(exp_q[i]));
    end
  endtask

  task automatic start_frame(cfg_t c);
    @(posedge clk); #1;
    cfg = c;
    run = 1'b1;
    @(posedge clk); #1;
    run = 1'b0;
  endtask

  task automatic wait_done(int target);
    while (done_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int base;
    logic [25:0] held;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!hdr_valid && !frame_done, "R1", "outputs in reset", {hdr_valid, frame_done}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      chk(!hdr_valid && !frame_done, "R1", "idle without run", {hdr_valid, frame_done}, 0);
    end

    bp_on = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      got.delete();
      exp_q.delete();
      build(ROWS[i]);
      base = done_cnt;
      start_frame(ROWS[i]);
      wait_done(base + 1);
      compare(row_tag(i));
    end

    // R12: settings changed mid-frame are not used
    got.delete();
    exp_q.delete();
    build(ROWS[0]);
    base = done_cnt;
    start_frame(ROWS[0]);
    repeat (6) @(posedge clk);
    #1;
    cfg = ROWS[1];
    wait_done(base + 1);
    compare("R12");

    // R11: header holds while stalled
    bp_on = 1'b0;
    got.delete();
    exp_q.delete();
    build(ROWS[1]);
    base = done_cnt;
    start_frame(ROWS[1]);
    repeat (7) @(posedge clk);
    #1;
    stall = 1'b1;
    @(negedge clk);
    held = {hdr_long, hdr_pix, hdr_id, hdr_wc};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(hdr_valid && ({hdr_long, hdr_pix, hdr_id, hdr_wc} == held), "R11", "stalled header",
          {hdr_valid, hdr_long, hdr_pix, hdr_id, hdr_wc}, {1'b1, held});
    end
    @(posedge clk); #1;
    stall = 1'b0;
    wait_done(base + 1);
    compare("R11");

    // R13: back-to-back frames and single-cycle end pulse
    bp_on = 1'b1;
    got.delete();
    exp_q.delete();
    build(ROWS[2]);
    build(ROWS[2]);
    base = done_cnt;
    @(posedge clk); #1;
    cfg = ROWS[2];
    run = 1'b1;
    while (done_cnt < base + 1) @(negedge clk);
    @(posedge clk); #1;
    run = 1'b0;
    wait_done(base + 2);
    compare("R13");
    repeat (20) @(negedge clk);
    chk(done_cnt == base + 2, "R13", "frame_done pulse count", 64'(done_cnt - base), 64'd2);
    chk(wide_done == 0, "R13", "frame_done wider than one cycle", 64'(wide_done), 64'd0);
    chk(!hdr_valid, "R1", "idle after run dropped", 64'(hdr_valid), 64'd0);

    summary();
  end

endmodule